// File: doc/BRIEF.md
# Abortable repeating sequence generator

This block is a small clocked state machine that drives a single-bit serial output. At rest it holds the output at 1. One cycle of a start request begins a five-step pattern, 1, 0, 1, 1, 1. The pattern then repeats without limit, even after the start request is gone.

An abort request stops the pattern at whichever step it has reached. The machine goes straight back to rest, and a new start request is needed to begin again. When both requests arrive together, the abort wins.

The output is decoded from the registered state only, so it changes just after a clock edge and never follows the inputs combinationally. The external reset is active low and takes effect asynchronously. Its release is synchronised inside the block, so the machine accepts requests from the third rising edge after the reset pin rises.

Top module: `seqgen_top`

## Requirements
- R1: While reset is asserted, and after it is released with no request pending, pattern_o reads 1.
- R2: At rest, with start_i and abort_i both low at an edge, the machine stays at rest and pattern_o stays 1.
- R3: When start_i is high and abort_i is low at an edge while at rest, pattern_o shows 1, 0, 1, 1, 1 in the five cycles after that edge, one value per cycle.
- R4: After the fifth value, the pattern starts again at its first value and keeps repeating for as long as abort_i stays low.
- R5: Once the pattern has started, start_i has no effect. Dropping it does not stop the pattern, and raising it again does not restart the pattern.
- R6: abort_i high at an edge, at any of the five steps, returns the machine to rest on that edge. pattern_o reads 1 from then on until a new start request is taken.
- R7: When start_i and abort_i are both high at an edge while at rest, the machine stays at rest.
- R8: abort_i high at an edge while at rest leaves the machine at rest with pattern_o at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, released synchronously inside the block |
| start_i | input | 1 | Start request, sampled on the rising edge |
| abort_i | input | 1 | Abort request, sampled on the rising edge; wins over start_i |
| pattern_o | output | 1 | Serial output: 1 at rest, otherwise the current pattern value |

## Verification
Start and abort can land on the same edge. The bench provokes this in two ways: it raises both requests at rest, and it holds start_i high during a running pattern while it aborts at each of the five steps.

Each case is judged against a cycle-accurate reference model that gives abort priority. The bench then keeps both inputs low for several more cycles. Rest and the first pattern step both read 1, so this extra window is what tells them apart: a missed abort shows up as a 0 appearing where only 1s are expected.

// File: rtl/seqgen_pkg.sv
package seqgen_pkg;
  localparam int unsigned PAT_LEN = 5;
  // value of step k sits in bit k
  localparam logic [PAT_LEN-1:0] PAT_BITS = 5'b11101;
  localparam int unsigned ST_W = $clog2(PAT_LEN + 1);
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [ST_W-1:0] {
    ST_REST = 3'd0,
    ST_P0   = 3'd1,
    ST_P1   = 3'd2,
    ST_P2   = 3'd3,
    ST_P3   = 3'd4,
    ST_P4   = 3'd5
  } seq_state_e;
endpackage

// File: rtl/seqgen_rst_sync.sv
module seqgen_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/seqgen_next.sv
module seqgen_next
  import seqgen_pkg::*;
(
  input  seq_state_e state_q,
  input  logic       start_i,
  input  logic       abort_i,
  output seq_state_e state_d
);
  always_comb begin
    state_d = state_q;
    if (abort_i) begin
      state_d = ST_REST;
    end else begin
      unique case (state_q)
        ST_REST: state_d = start_i ? ST_P0 : ST_REST;
        ST_P0:   state_d = ST_P1;
        ST_P1:   state_d = ST_P2;
        ST_P2:   state_d = ST_P3;
        ST_P3:   state_d = ST_P4;
        ST_P4:   state_d = ST_P0;
        default: state_d = ST_REST;
      endcase
    end
  end
endmodule

// File: rtl/seqgen_decode.sv
module seqgen_decode
  import seqgen_pkg::*;
(
  input  seq_state_e state_q,
  output logic       bit_o
);
  always_comb begin
    unique case (state_q)
      ST_P0:   bit_o = PAT_BITS[0];
      ST_P1:   bit_o = PAT_BITS[1];
      ST_P2:   bit_o = PAT_BITS[2];
      ST_P3:   bit_o = PAT_BITS[3];
      ST_P4:   bit_o = PAT_BITS[4];
      default: bit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/seqgen_top.sv
module seqgen_top
  import seqgen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic abort_i,
  output logic pattern_o
);
  logic       rst_sync_n;
  logic       state_en;
  seq_state_e state_q;
  seq_state_e state_d;

  seqgen_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  seqgen_next u_next (
    .state_q (state_q),
    .start_i (start_i),
    .abort_i (abort_i),
    .state_d (state_d)
  );

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_REST;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  seqgen_decode u_decode (
    .state_q (state_q),
    .bit_o   (pattern_o)
  );
endmodule

// File: rtl/seqgen_chk.sv
module seqgen_chk
  import seqgen_pkg::*;
(
  input logic       clk,
  input logic       rst_sync_n,
  input logic       start_i,
  input logic       abort_i,
  input logic       pattern_o,
  input seq_state_e state_q
);
  AST_REST_OUT_ONE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_REST) |-> pattern_o); // R1
  AST_REST_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_REST && !start_i && !abort_i) |=> (state_q == ST_REST)); // R2
  AST_START_ENTER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_REST && start_i && !abort_i) |=> (state_q == ST_P0 && pattern_o)); // R3
  AST_ZERO_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pattern_o |-> (state_q == ST_P1)); // R3
  AST_WRAP_AROUND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_P4 && !abort_i) |=> (state_q == ST_P0)); // R4
  AST_RUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q != ST_REST && !abort_i) |=> (state_q != ST_REST && state_q != $past(state_q))); // R5
  AST_ABORT_REST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    abort_i |=> (state_q == ST_REST && pattern_o)); // R6
  AST_BOTH_REST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start_i && abort_i && state_q == ST_REST) |=> (state_q == ST_REST)); // R7
endmodule

bind seqgen_top seqgen_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .start_i    (start_i),
  .abort_i    (abort_i),
  .pattern_o  (pattern_o),
  .state_q    (state_q)
);

// File: tb/tb_seqgen_top.sv
`timescale 1ns/1ps
module tb_seqgen_top;
  logic clk;
  logic rst_n;
  logic start_i;
  logic abort_i;
  logic pattern_o;

  int checks;
  int errors;
  int mpos;
  bit finished;
  bit pat [5] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1};

  seqgen_top dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .abort_i   (abort_i),
    .pattern_o (pattern_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pattern_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, compare at the next falling edge
  task automatic step(input logic s, input logic a, input string req);
    start_i = s;
    abort_i = a;
    @(posedge clk);
    if (a) mpos = -1;
    else if (mpos < 0 && s) mpos = 0;
    else if (mpos >= 0) mpos = (mpos + 1) % 5;
    @(negedge clk);
    check(req, pattern_o, (mpos < 0) ? 1'b1 : pat[mpos]);
  endtask

  task automatic t_reset();
    start_i = 1'b0;
    abort_i = 1'b0;
    rst_n   = 1'b0;
    mpos    = -1;
    repeat (3) @(negedge clk);
    check("R1", pattern_o, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", pattern_o, 1'b1);
  endtask

  task automatic t_rest_hold();
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, "R2");
  endtask

  task automatic t_pattern_loop();
    step(1'b1, 1'b0, "R3");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, "R3");
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0, "R4");
    step(1'b0, 1'b1, "R6");
  endtask

  task automatic t_start_ignored();
    step(1'b1, 1'b0, "R3");
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, "R5");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, "R5");
    step(1'b0, 1'b1, "R6");
  endtask

  task automatic t_abort_each();
    for (int k = 0; k < 5; k++) begin
      step(1'b1, 1'b0, "R3");
      for (int j = 0; j < k; j++) step(1'b0, 1'b0, "R3");
      step(1'b1, 1'b1, "R6");
      for (int j = 0; j < 6; j++) step(1'b0, 1'b0, "R6");
    end
  endtask

  task automatic t_both_rest();
    step(1'b1, 1'b1, "R7");
    for (int j = 0; j < 6; j++) step(1'b0, 1'b0, "R7");
  endtask

  task automatic t_abort_rest();
    step(1'b0, 1'b1, "R8");
    for (int j = 0; j < 6; j++) step(1'b0, 1'b0, "R8");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: run hung, actual running expected done");
    finish_run();
  end

  initial begin
    checks = 0;
    errors = 0;
    finished = 1'b0;
    @(negedge clk);
    t_reset();
    t_rest_hold();
    t_pattern_loop();
    t_start_ignored();
    t_abort_each();
    t_both_rest();
    t_abort_rest();
    t_pattern_loop();
    finish_run();
  end
endmodule